// File: doc/BRIEF.md
# Slack-Time Monitor Header Stage

This block sits beside one processing element of a pixel-streaming pipeline. It follows the pixel flow with a column counter and a row counter whose limits come from the in-band frame header. When the last pixel of the last row has been accepted, it measures how many idle clock cycles pass before the next frame-sync pulse. That figure is the stage's slack for the frame period.

The measured slack travels downstream inside the header of the next frame. Each header word is 36 bits wide: a 4-bit code in bits 35:32 and a 32-bit value in bits 31:0. Every word crosses the stage one clock later. A slack word is rewritten so that it carries the smaller of its incoming value and this stage's own figure. Chaining stages therefore leaves the pipeline-wide minimum at the far end. If a header carries no slack word, the stage adds one immediately ahead of the stop word.

Codes used: 1111 first start word, 1010 second start word, 1110 stop word, 0000 empty delay word, 0010 frame width, 0011 frame height, 0100 slack. Any other code (for example 0001, frame rate) passes untouched.

Top module: `slk_hdr_stage`

## Requirements
- R1: A header word is {code[3:0], value[31:0]}. The code occupies bits 35:32, and the codes listed above are decoded.
- R2: Every valid header word appears on the output exactly one cycle after it is accepted. Words other than slack (0100) and stop (1110) come out bit-for-bit unchanged.
- R3: A width (0010) or height (0011) word loads the matching counter limit from value bits 12:0. Bit 13 is an update flag and never affects the limit.
- R4: A frame ends on the accepted pixel that completes width x height accepted pixels since the last frame-sync or reset.
- R5: At a frame-sync pulse, the stage's slack becomes the number of clock cycles strictly between the frame-ending pixel cycle and the frame-sync cycle.
- R6: Pixel-valid pulses between the end of a frame and the next frame-sync are ignored: they neither shorten the slack count nor start a new frame.
- R7: A frame-sync that arrives before the current frame has ended sets the slack to 0, provided a frame end has been seen at some point since reset.
- R8: Until the first frame-sync that follows a frame end after reset, the stage's slack is all ones (0xFFFFFFFF).
- R9: An incoming slack word leaves with code 0100 and a value equal to the minimum of its own value and the stage's slack.
- R10: If a header reaches its stop word without having carried a slack word since the first start word, a slack word holding the stage's slack is emitted in the stop word's slot. The stop word follows one cycle later.
- R11: Input contract: the cycle after a stop word has no valid header word.
- R12: After reset, the header output is not valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync_i | input | 1 | Frame-sync pulse, one cycle |
| pix_vld_i | input | 1 | Pixel accepted by the neighbouring processing element |
| hdr_vld_i | input | 1 | Header input word valid |
| hdr_dat_i | input | 36 | Header input word |
| hdr_vld_o | output | 1 | Header output word valid |
| hdr_dat_o | output | 36 | Header output word |

## Verification
The bound checker watches the header path on every cycle. It checks that each word appears one cycle later, that pass-through words are unaltered, that a forwarded slack value never grows, that every outgoing stop word is preceded by a slack word within its header, that the input gap after a stop word is respected, and that the output is idle after reset. The exact slack figure can only be shown by the bench's scenarios, because it depends on long stretches of pixel and sync stimulus. The same holds for the sentinel before the first frame, the zero on an overrun, the masking of the width flag and the indifference to stray idle pixels.

// File: rtl/slk_pkg.sv
package slk_pkg;
   localparam int CODE_W = 4;
   localparam int VAL_W  = 32;
   localparam int HDR_W  = CODE_W + VAL_W;

   typedef logic [CODE_W-1:0] code_t;
   typedef logic [VAL_W-1:0]  val_t;
   typedef logic [HDR_W-1:0]  word_t;

   localparam code_t K_START0 = 4'b1111;
   localparam code_t K_START1 = 4'b1010;
   localparam code_t K_STOP   = 4'b1110;
   localparam code_t K_DELAY  = 4'b0000;
   localparam code_t K_WIDTH  = 4'b0010;
   localparam code_t K_HEIGHT = 4'b0011;
   localparam code_t K_SLACK  = 4'b0100;

   function automatic code_t code_of(input word_t w);
      return w[HDR_W-1 -: CODE_W];
   endfunction

   function automatic val_t val_of(input word_t w);
      return w[VAL_W-1:0];
   endfunction
endpackage

// File: rtl/slk_frame_ctr.sv
// Column/row tracker: flags the pixel that completes a frame.
module slk_frame_ctr #(
   parameter int LIM_W     = 13,
   parameter int DEF_WIDTH = 640,
   parameter int DEF_HGT   = 480
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fsync_i,
   input  logic             pix_vld_i,
   input  logic             wr_w_i,
   input  logic             wr_h_i,
   input  logic [LIM_W-1:0] lim_i,
   output logic             frame_end_o,
   output logic             done_o
);
   localparam logic [LIM_W-1:0] ONE = LIM_W'(1);

   logic [LIM_W-1:0] w_q, h_q, col_q, row_q;
   logic             done_q;
   logic             acc, last_col, last_row;

   // pixels count only while a frame is open and no sync is present
   assign acc         = pix_vld_i && !fsync_i && !done_q;
   assign last_col    = (col_q == w_q - ONE);
   assign last_row    = (row_q == h_q - ONE);
   assign frame_end_o = acc && last_col && last_row;
   assign done_o      = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         w_q <= LIM_W'(DEF_WIDTH);
         h_q <= LIM_W'(DEF_HGT);
      end else begin
         if (wr_w_i) w_q <= lim_i;
         if (wr_h_i) h_q <= lim_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col_q  <= '0;
         row_q  <= '0;
         done_q <= 1'b0;
      end else if (fsync_i) begin
         col_q  <= '0;
         row_q  <= '0;
         done_q <= 1'b0;
      end else if (acc) begin
         if (last_col) begin
            col_q <= '0;
            if (last_row) begin
               row_q  <= '0;
               done_q <= 1'b1;
            end else begin
               row_q <= row_q + ONE;
            end
         end else begin
            col_q <= col_q + ONE;
         end
      end
   end
endmodule

// File: rtl/slk_idle_meter.sv
// Counts idle cycles from frame end to frame-sync and holds the result.
module slk_idle_meter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fsync_i,
   input  logic             frame_end_i,
   output logic [CNT_W-1:0] rep_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic             idle_q, ever_q;
   logic [CNT_W-1:0] cnt_q, rep_q;

   assign rep_o = rep_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idle_q <= 1'b0;
         ever_q <= 1'b0;
         cnt_q  <= '0;
         rep_q  <= CNT_MAX;
      end else if (fsync_i) begin
         idle_q <= 1'b0;
         if (idle_q)      rep_q <= cnt_q;
         else if (ever_q) rep_q <= '0;   // frame overran its period
      end else if (frame_end_i) begin
         idle_q <= 1'b1;
         ever_q <= 1'b1;
         cnt_q  <= '0;
      end else if (idle_q && cnt_q != CNT_MAX) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/slk_hdr_merge.sv
// Header path: one-cycle forwarding, dimension decode, slack merge/insert.
module slk_hdr_merge
   import slk_pkg::*;
#(
   parameter int DIM_W   = 14,
   parameter int SLACK_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               vld_i,
   input  word_t              dat_i,
   input  logic [SLACK_W-1:0] rep_i,
   output logic               vld_o,
   output word_t              dat_o,
   output logic               wr_w_o,
   output logic               wr_h_o,
   output logic [DIM_W-2:0]   lim_o
);
   code_t in_code;
   val_t  in_val, rep_ext, merged;
   logic  vld_q, pend_q, seen_q;
   word_t dat_q, stop_q;

   assign in_code = code_of(dat_i);
   assign in_val  = val_of(dat_i);

   generate
      if (SLACK_W == VAL_W) begin : g_rep_full
         assign rep_ext = rep_i;
      end else begin : g_rep_pad
         assign rep_ext = {{(VAL_W-SLACK_W){1'b0}}, rep_i};
      end
   endgenerate

   assign merged = (rep_ext < in_val) ? rep_ext : in_val;

   // flag bit DIM_W-1 is dropped from the limit
   assign lim_o  = in_val[DIM_W-2:0];
   assign wr_w_o = vld_i && (in_code == K_WIDTH);
   assign wr_h_o = vld_i && (in_code == K_HEIGHT);

   assign vld_o = vld_q;
   assign dat_o = dat_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         dat_q  <= '0;
         pend_q <= 1'b0;
         seen_q <= 1'b0;
         stop_q <= '0;
      end else if (pend_q) begin
         vld_q  <= 1'b1;
         dat_q  <= stop_q;
         pend_q <= 1'b0;
      end else if (vld_i) begin
         vld_q <= 1'b1;
         dat_q <= dat_i;
         unique case (in_code)
            K_START0: seen_q <= 1'b0;
            K_SLACK: begin
               seen_q <= 1'b1;
               dat_q  <= {K_SLACK, merged};
            end
            K_STOP: begin
               seen_q <= 1'b0;
               if (!seen_q) begin
                  dat_q  <= {K_SLACK, rep_ext};
                  stop_q <= dat_i;
                  pend_q <= 1'b1;
               end
            end
            default: ;
         endcase
      end else begin
         vld_q <= 1'b0;
      end
   end
endmodule

// File: rtl/slk_hdr_stage.sv
module slk_hdr_stage
   import slk_pkg::*;
#(
   parameter int DIM_W     = 14,
   parameter int SLACK_W   = 32,
   parameter int DEF_WIDTH = 640,
   parameter int DEF_HGT   = 480
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fsync_i,
   input  logic             pix_vld_i,
   input  logic             hdr_vld_i,
   input  logic [HDR_W-1:0] hdr_dat_i,
   output logic             hdr_vld_o,
   output logic [HDR_W-1:0] hdr_dat_o
);
   localparam int LIM_W = DIM_W - 1;

   generate
      if (DIM_W < 2 || DIM_W > VAL_W) begin : g_bad_dim
         $error("slk_hdr_stage: DIM_W out of range");
      end
      if (SLACK_W < 1 || SLACK_W > VAL_W) begin : g_bad_slack
         $error("slk_hdr_stage: SLACK_W out of range");
      end
      if (DEF_WIDTH < 1 || DEF_HGT < 1) begin : g_bad_def
         $error("slk_hdr_stage: default dimensions must be nonzero");
      end
   endgenerate

   logic               wr_w, wr_h, frame_end, done;
   logic [LIM_W-1:0]   lim;
   logic [SLACK_W-1:0] rep;

   slk_frame_ctr #(
      .LIM_W(LIM_W), .DEF_WIDTH(DEF_WIDTH), .DEF_HGT(DEF_HGT)
   ) u_frame (
      .clk(clk), .rst_n(rst_n), .fsync_i(fsync_i), .pix_vld_i(pix_vld_i),
      .wr_w_i(wr_w), .wr_h_i(wr_h), .lim_i(lim),
      .frame_end_o(frame_end), .done_o(done)
   );

   slk_idle_meter #(.CNT_W(SLACK_W)) u_meter (
      .clk(clk), .rst_n(rst_n), .fsync_i(fsync_i),
      .frame_end_i(frame_end), .rep_o(rep)
   );

   slk_hdr_merge #(.DIM_W(DIM_W), .SLACK_W(SLACK_W)) u_merge (
      .clk(clk), .rst_n(rst_n), .vld_i(hdr_vld_i), .dat_i(hdr_dat_i),
      .rep_i(rep), .vld_o(hdr_vld_o), .dat_o(hdr_dat_o),
      .wr_w_o(wr_w), .wr_h_o(wr_h), .lim_o(lim)
   );

   logic unused_done;
   assign unused_done = done;
endmodule

// File: rtl/slk_hdr_stage_chk.sv
module slk_hdr_stage_chk
   import slk_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             hdr_vld_i,
   input logic [HDR_W-1:0] hdr_dat_i,
   input logic             hdr_vld_o,
   input logic [HDR_W-1:0] hdr_dat_o
);
   code_t ci, co;
   logic  out_seen_q;
   assign ci = code_of(hdr_dat_i);
   assign co = code_of(hdr_dat_o);

   // tracks slack words seen on the output side of the current header
   always_ff @(posedge clk) begin
      if (!rst_n) out_seen_q <= 1'b0;
      else if (hdr_vld_o) begin
         if (co == K_SLACK)                     out_seen_q <= 1'b1;
         else if (co == K_STOP || co == K_START0) out_seen_q <= 1'b0;
      end
   end

   a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_vld_i |=> hdr_vld_o);

   a_r2_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_vld_i && ci != K_SLACK && ci != K_STOP |=> hdr_dat_o == $past(hdr_dat_i));

   a_r9_never_grows: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_vld_i && ci == K_SLACK |=>
         code_of(hdr_dat_o) == K_SLACK && val_of(hdr_dat_o) <= val_of($past(hdr_dat_i)));

   a_r10_slack_before_stop: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_vld_o && co == K_STOP |-> out_seen_q);

   a_r11_gap_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_vld_i && ci == K_STOP |=> !hdr_vld_i);

   a_r12_idle_out_of_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !hdr_vld_o);
endmodule

bind slk_hdr_stage slk_hdr_stage_chk u_chk (
   .clk(clk), .rst_n(rst_n), .hdr_vld_i(hdr_vld_i), .hdr_dat_i(hdr_dat_i),
   .hdr_vld_o(hdr_vld_o), .hdr_dat_o(hdr_dat_o)
);

// File: tb/slk_hdr_stage_tb_top.sv
module slk_hdr_stage_tb_top;
   localparam int CLK_T = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fsync = 1'b0, pix = 1'b0, hv_i = 1'b0;
   logic [35:0] hd_i = '0;
   logic        hv_o;
   logic [35:0] hd_o;

   int n_run = 0, n_fail = 0, cyc = 0;
   logic [35:0] w_in [16];
   int          n_in, in_cyc0, in_stop_cyc;
   logic [35:0] cap [32];
   int          cap_cyc [32];
   int          ncap = 0;

   always #(CLK_T/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   slk_hdr_stage dut_i (
      .clk(clk), .rst_n(rst_n), .fsync_i(fsync), .pix_vld_i(pix),
      .hdr_vld_i(hv_i), .hdr_dat_i(hd_i), .hdr_vld_o(hv_o), .hdr_dat_o(hd_o)
   );

   always @(negedge clk) if (hv_o && ncap < 32) begin
      cap[ncap] = hd_o; cap_cyc[ncap] = cyc; ncap = ncap + 1;
   end

   function automatic logic [35:0] mk(input logic [3:0] c, input logic [31:0] v);
      return {c, v};
   endfunction

   task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic step(); @(posedge clk); #1; endtask

   task automatic send();
      ncap = 0;
      for (int i = 0; i < n_in; i++) begin
         hv_i = 1'b1; hd_i = w_in[i];
         if (i == 0) in_cyc0 = cyc;
         in_stop_cyc = cyc;
         step();
      end
      hv_i = 1'b0; hd_i = '0;
      repeat (4) step();
   endtask

   task automatic pixels(input int n);
      for (int i = 0; i < n; i++) begin pix = 1'b1; step(); end
      pix = 1'b0;
   endtask

   task automatic sync();
      fsync = 1'b1; step(); fsync = 1'b0; step();
   endtask

   task automatic expect_slack_insert(input logic [31:0] v, input string tag);
      w_in[0] = mk(4'hF, 0); w_in[1] = mk(4'hA, 0); w_in[2] = mk(4'hE, 0); n_in = 3;
      send();
      chk(ncap == 4, {tag, " word count"}, ncap, 4);
      chk(cap[2] == mk(4'h4, v), {tag, " slack value"}, cap[2], mk(4'h4, v));
   endtask

   // R12 reset state, R8 sentinel, R10 insertion, R2 latency, R1 codes
   task automatic t_reset_and_sentinel();
      chk(hv_o == 1'b0, "R12 output idle after reset", hv_o, 0);
      w_in[0] = mk(4'hF, 0); w_in[1] = mk(4'hA, 0); w_in[2] = mk(4'h2, 4);
      w_in[3] = mk(4'h3, 3); w_in[4] = mk(4'h1, 30); w_in[5] = mk(4'hE, 0); n_in = 6;
      send();
      chk(ncap == 7, "R10 inserted word count", ncap, 7);
      chk(cap_cyc[0] == in_cyc0 + 1, "R2 latency one cycle", cap_cyc[0] - in_cyc0, 1);
      for (int i = 0; i < 5; i++)
         chk(cap[i] == w_in[i], "R2 word unchanged", cap[i], w_in[i]);
      chk(cap[5] == mk(4'h4, 32'hFFFF_FFFF), "R8 all-ones before first frame", cap[5], mk(4'h4, 32'hFFFF_FFFF));
      chk(cap[6] == mk(4'hE, 0), "R10 stop after insert", cap[6], mk(4'hE, 0));
      chk(cap_cyc[6] == in_stop_cyc + 2, "R10 stop delayed", cap_cyc[6] - in_stop_cyc, 2);
   endtask

   // R4 R5 measurement, R9 merge both ways
   task automatic t_measure_merge();
      sync(); pixels(12); repeat (7) step(); sync();
      w_in[0] = mk(4'hF, 0); w_in[1] = mk(4'hA, 0); w_in[2] = mk(4'h4, 1000);
      w_in[3] = mk(4'h0, 0); w_in[4] = mk(4'hE, 0); n_in = 5;
      send();
      chk(ncap == 5, "R9 no insert when present", ncap, 5);
      chk(cap[2] == mk(4'h4, 7), "R5 R9 slack replaces larger", cap[2], mk(4'h4, 7));
      chk(cap[3] == mk(4'h0, 0), "R2 delay word passes", cap[3], mk(4'h0, 0));
      chk(cap_cyc[4] == in_stop_cyc + 1, "R2 stop latency", cap_cyc[4] - in_stop_cyc, 1);
      w_in[2] = mk(4'h4, 3);
      send();
      chk(cap[2] == mk(4'h4, 3), "R9 smaller kept", cap[2], mk(4'h4, 3));
      expect_slack_insert(7, "R10 insert measured");
   endtask

   // R7 overrun and R4 frame not ended early
   task automatic t_overrun();
      pixels(5); repeat (2) step(); sync();
      expect_slack_insert(0, "R7 overrun");
   endtask

   // R3 flag masked, R6 idle pixels ignored, R4 short frame
   task automatic t_mask_and_idle();
      w_in[0] = mk(4'hF, 0); w_in[1] = mk(4'h2, 32'h2004); w_in[2] = mk(4'h3, 32'h2002);
      w_in[3] = mk(4'hE, 0); n_in = 4;
      send();
      sync(); pixels(8); repeat (5) step(); sync();
      expect_slack_insert(5, "R3 flag masked");
      pixels(8); repeat (3) step(); pixels(2); repeat (3) step(); sync();
      expect_slack_insert(8, "R6 idle pixels ignored");
      pixels(7); repeat (4) step(); sync();
      expect_slack_insert(0, "R4 frame needs all pixels");
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset_and_sentinel();
      t_measure_merge();
      t_overrun();
      t_mask_and_idle();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule